// File: doc/BRIEF.md
# CAN Error-State Interrupt Flag Register

This block keeps the sticky interrupt status word of a CAN controller. It watches the 9-bit transmit and receive error counters and raises a flag each time a counter climbs into the warning, error-passive or bus-off zone of the CAN fault-confinement rules. It also records overload-frame transmission, completed reset processing, and frames stored into mailboxes. All counter values and event pulses come from the surrounding controller.

Software reads the status word and an interrupt mask word through a one-bit-addressed register port. Most status bits are cleared by writing 1. The two mailbox flags are read-only. Each of them drops by itself once no unmasked mailbox still has a pending bit. A single interrupt request is raised while any status bit is set and not masked.

Top module: `can_eirq_regs`

## Requirements
- R1: After synchronous reset the status word reads 16'h0001, with only the reset flag (bit 0) set. The mask word reads 16'hFFFF and irq_req is 0.
- R2: Bus-off flag, bit 7: it sets when tx_err_cnt changes from below 256 to 256 or more.
- R3: Error-passive flag, bit 6: it sets when the condition (tx_err_cnt >= 128 or rx_err_cnt >= 128) changes from false to true.
- R4: Receive warning flag, bit 5: it sets when rx_err_cnt rises to 96 or more. Transmit warning flag, bit 4: it sets when tx_err_cnt rises to 96 or more.
- R5: A threshold flag that has been cleared stays clear while its condition holds. It can set again only after the condition has first gone false.
- R6: The overload flag (bit 8) sets in the cycle after an ovl_sent pulse. The reset flag (bit 0) sets in the cycle after a rst_done pulse.
- R7: A write with reg_sel=0 clears each of bits 8, 7, 6, 5, 4 and 0 whose write-data bit is 1. A write-data bit of 0 leaves its flag unchanged.
- R8: When a flag's set condition and a write-1 clear fall in the same cycle, the flag ends that cycle set.
- R9: Receive flag, bit 1: it sets when store_vld is 1 and mb_irq_mask[store_idx] is 0. It ignores writes. It clears in any cycle with no such store and (rx_pend & ~mb_irq_mask) equal to 0.
- R10: Remote-request flag, bit 2: it works like R9, but it sets only when store_remote is also 1, and it clears on rmt_pend.
- R11: Bits 3 and 15 to 9 of the status word always read 0.
- R12: A write with reg_sel=1 loads the mask word, and the mask reads back with reg_sel=1. irq_req equals the OR of (status & ~mask), so a mask bit of 1 disables its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_cnt | input | 9 | Transmit error counter |
| rx_err_cnt | input | 9 | Receive error counter |
| ovl_sent | input | 1 | Pulse: overload frame transmitted |
| rst_done | input | 1 | Pulse: reset processing completed |
| store_vld | input | 1 | Pulse: frame stored into a mailbox |
| store_idx | input | $clog2(NMB) (3) | Mailbox index of the stored frame |
| store_remote | input | 1 | Stored frame is a remote frame |
| rx_pend | input | NMB (8) | Receive-pending bit of each mailbox |
| rmt_pend | input | NMB (8) | Remote-request-pending bit of each mailbox |
| mb_irq_mask | input | NMB (8) | Mailbox interrupt mask, 1 = masked |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status word, 1 = mask word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected word |
| irq_req | output | 1 | Combined interrupt request |

## Verification
A flag's own set event and a software write-1 clear of that same flag can arrive in one cycle. The bench provokes this directly: it raises the receive counter to 96 while writing 1 to bit 5, and it pulses rst_done together with a clear of bit 0. The random phase also overlaps writes with counter jumps and event pulses. A per-cycle reference model judges every collision with the set-wins rule, so a flag found clear after a collision counts as a mismatch.

// File: rtl/can_eirq_pkg.sv
// Package: shared constants for the CAN error-state interrupt flag register.
// Assumes 9-bit error counters so that 256 is representable.
package can_eirq_pkg;
    localparam int FLAG_W   = 16;
    localparam int CNT_W    = 9;
    localparam int LIM_WARN = 96;
    localparam int LIM_PASS = 128;
    localparam int LIM_BOFF = 256;
    localparam int BIT_RST  = 0;
    localparam int BIT_RXM  = 1;
    localparam int BIT_RMT  = 2;
    localparam int BIT_OVL  = 8;
    localparam int THR_TOP  = 7;   // threshold flags occupy bits 7 down to 4
    localparam int N_THR    = 4;
    localparam logic [FLAG_W-1:0] W1C_BITS  = 16'h01F1;
    localparam logic [FLAG_W-1:0] FLAG_RST  = 16'h0001;
    localparam logic [FLAG_W-1:0] MASK_RST  = 16'hFFFF;
    typedef enum logic {SEL_FLAGS = 1'b0, SEL_MASK = 1'b1} reg_sel_e;
endpackage

// File: rtl/can_eirq_cross.sv
// Threshold crossing detector: compares the watched counter(s) against a
// fixed limit and emits a one-cycle rise pulse when the condition goes true.
// Assumes counters are stable within a cycle; previous level resets to 0.
module can_eirq_cross #(
    parameter int CNT_W    = 9,
    parameter int LIMIT    = 96,
    parameter bit WATCH_TX = 1'b1,
    parameter bit WATCH_RX = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    output logic             rise
);
    localparam logic [CNT_W-1:0] LIM_V = LIMIT[CNT_W-1:0];

    logic tx_hi, rx_hi, level, level_q;

    // Combine the enabled comparisons into one condition level.
    always_comb begin
        tx_hi = (tx_cnt >= LIM_V);
        rx_hi = (rx_cnt >= LIM_V);
        level = (WATCH_TX & tx_hi) | (WATCH_RX & rx_hi);
        rise  = level & ~level_q;
    end

    // Remember the previous condition level to detect the upward crossing.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assert_single_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/can_eirq_w1c.sv
// Sticky flag bit with write-1-to-clear; set has priority over clear.
// Assumes set and clr are single-cycle qualified strobes.
module can_eirq_w1c #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag; a set event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= RST_VAL;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    assert_clear_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/can_eirq_mbox.sv
// Mailbox-derived read-only flag: sets when a qualifying frame is stored in
// an unmasked mailbox; clears once no unmasked mailbox has a pending bit.
// Assumes the pending vector is updated by the mailbox logic after a store.
module can_eirq_mbox #(
    parameter int NMB   = 8,
    parameter int IDX_W = $clog2(NMB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store,
    input  logic [IDX_W-1:0] store_idx,
    input  logic [NMB-1:0]   mb_mask,
    input  logic [NMB-1:0]   pend,
    output logic             flag
);
    logic hit, any_live;

    // Qualify the store by the target mailbox mask; reduce live pendings.
    always_comb begin
        hit      = store & ~mb_mask[store_idx];
        any_live = |(pend & ~mb_mask);
    end

    // Sticky while any unmasked pending bit remains.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (hit)       flag <= 1'b1;
        else if (!any_live) flag <= 1'b0;
    end

    assert_store_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    assert_idle_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!store && ((pend & ~mb_mask) == '0)) |=> !flag);
endmodule

// File: rtl/can_eirq_regs.sv
// Top: CAN error-state interrupt flag register with mask and combined IRQ.
// Assumes counters and event pulses come from the controller core and that
// reads are combinational on reg_sel.
module can_eirq_regs
    import can_eirq_pkg::*;
#(
    parameter int NMB = 8,
    localparam int IDX_W = $clog2(NMB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tx_err_cnt,
    input  logic [CNT_W-1:0]  rx_err_cnt,
    input  logic              ovl_sent,
    input  logic              rst_done,
    input  logic              store_vld,
    input  logic [IDX_W-1:0]  store_idx,
    input  logic              store_remote,
    input  logic [NMB-1:0]    rx_pend,
    input  logic [NMB-1:0]    rmt_pend,
    input  logic [NMB-1:0]    mb_irq_mask,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [FLAG_W-1:0] reg_wdata,
    output logic [FLAG_W-1:0] reg_rdata,
    output logic              irq_req
);
    logic [FLAG_W-1:0] flags, set_vec, clr_vec, mask_q;
    logic [N_THR-1:0]  thr_rise;

    // Threshold detectors: g0 bus-off, g1 passive, g2 rx warn, g3 tx warn.
    for (genvar g = 0; g < N_THR; g++) begin : g_thr
        localparam int LIM = (g == 0) ? LIM_BOFF : (g == 1) ? LIM_PASS : LIM_WARN;
        can_eirq_cross #(
            .CNT_W(CNT_W), .LIMIT(LIM),
            .WATCH_TX(g != 2), .WATCH_RX(g == 1 || g == 2)
        ) u_cross (
            .clk(clk), .rst_n(rst_n),
            .tx_cnt(tx_err_cnt), .rx_cnt(rx_err_cnt),
            .rise(thr_rise[g])
        );
    end

    // Gather set events and write-1 clears into per-bit vectors.
    always_comb begin
        set_vec          = '0;
        set_vec[BIT_OVL] = ovl_sent;
        set_vec[BIT_RST] = rst_done;
        for (int g = 0; g < N_THR; g++) set_vec[THR_TOP-g] = thr_rise[g];
        clr_vec = (reg_wr && reg_sel == SEL_FLAGS) ? (reg_wdata & W1C_BITS) : '0;
    end

    // Per-bit flag variants chosen by bit position.
    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
        if (W1C_BITS[b]) begin : g_w1c
            can_eirq_w1c #(.RST_VAL(FLAG_RST[b])) u_flag (
                .clk(clk), .rst_n(rst_n),
                .set(set_vec[b]), .clr(clr_vec[b]), .flag(flags[b])
            );
        end else if (b == BIT_RXM) begin : g_rxm
            can_eirq_mbox #(.NMB(NMB)) u_flag (
                .clk(clk), .rst_n(rst_n), .store(store_vld),
                .store_idx(store_idx), .mb_mask(mb_irq_mask),
                .pend(rx_pend), .flag(flags[b])
            );
        end else if (b == BIT_RMT) begin : g_rmt
            can_eirq_mbox #(.NMB(NMB)) u_flag (
                .clk(clk), .rst_n(rst_n), .store(store_vld & store_remote),
                .store_idx(store_idx), .mb_mask(mb_irq_mask),
                .pend(rmt_pend), .flag(flags[b])
            );
        end else begin : g_rsv
            assign flags[b] = 1'b0;
        end
    end

    // Interrupt mask word, loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                            mask_q <= MASK_RST;
        else if (reg_wr && reg_sel == SEL_MASK) mask_q <= reg_wdata;
    end

    // Read mux and combined interrupt request.
    always_comb begin
        reg_rdata = (reg_sel == SEL_MASK) ? mask_q : flags;
        irq_req   = |(flags & ~mask_q);
    end

    assert_masked_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == MASK_RST) |-> !irq_req);
    assert_mask_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_MASK) |=> (mask_q == $past(reg_wdata)));
    assert_ovl_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_sent |=> flags[BIT_OVL]);
endmodule

// File: tb/can_eirq_regs_tb.sv
`timescale 1ns/1ps
module can_eirq_regs_tb;
    localparam int NMB = 8;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [8:0]  tx, rx;
    logic        ovl, rdn, svld, srmt, wr, sel;
    logic [2:0]  sidx;
    logic [7:0]  rxp, rmp, mbm;
    logic [15:0] wd, rdata;
    logic        irq;

    logic [15:0] mf, mm;
    logic [3:0]  prv;
    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    can_eirq_regs #(.NMB(NMB)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx), .rx_err_cnt(rx),
        .ovl_sent(ovl), .rst_done(rdn), .store_vld(svld), .store_idx(sidx),
        .store_remote(srmt), .rx_pend(rxp), .rmt_pend(rmp), .mb_irq_mask(mbm),
        .reg_wr(wr), .reg_sel(sel), .reg_wdata(wd), .reg_rdata(rdata),
        .irq_req(irq)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        ovl = 0; rdn = 0; svld = 0; srmt = 0; sidx = 0; wr = 0; wd = 0;
    endtask

    // Reference model: next state from the requirements, before the edge.
    task automatic model_step();
        logic [3:0]  lv;
        logic [15:0] s;
        logic        hit;
        lv[0] = (tx >= 9'd256);
        lv[1] = (tx >= 9'd128) || (rx >= 9'd128);
        lv[2] = (rx >= 9'd96);
        lv[3] = (tx >= 9'd96);
        s = '0;
        for (int g = 0; g < 4; g++) s[7-g] = lv[g] & ~prv[g];
        s[8] = ovl; s[0] = rdn;
        hit = svld && !mbm[sidx];
        for (int b = 0; b < 16; b++) begin
            if (b == 0 || (b >= 4 && b <= 8))
                mf[b] = s[b] | (mf[b] & ~(wr && !sel && wd[b]));
        end
        mf[1] = hit | (mf[1] & (|(rxp & ~mbm)));
        mf[2] = (hit & srmt) | (mf[2] & (|(rmp & ~mbm)));
        if (wr && sel) mm = wd;
        prv = lv;
    endtask

    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, rdata, sel ? mm : mf);
        check({tag, " R12 irq"}, {15'd0, irq}, {15'd0, |(mf & ~mm)});
        quiet();
    endtask

    function automatic logic [8:0] pick_cnt();
        case ($urandom % 9)
            0: return 9'd0;   1: return 9'd95;  2: return 9'd96;
            3: return 9'd127; 4: return 9'd128; 5: return 9'd255;
            6: return 9'd256; 7: return 9'd300;
            default: return 9'($urandom % 512);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd1234));
        tx = 0; rx = 0; rxp = 0; rmp = 0; mbm = 0; sel = 0;
        quiet();
        mf = 16'h0001; mm = 16'hFFFF; prv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); @(negedge clk);
        check("R1 reset flags", rdata, 16'h0001);
        check("R1 reset irq", {15'd0, irq}, 16'd0);
        sel = 1; #0.1;
        check("R1 reset mask", rdata, 16'hFFFF);
        sel = 0;
        model_step();  // idle cycle already elapsed, counters at zero

        tx = 9'd96;  cyc("R4 tx warn");
        check("R4 tx warn literal", rdata, 16'h0011);
        tx = 9'd128; cyc("R3 passive");
        tx = 9'd256; cyc("R2 bus-off");
        check("R2 bus-off literal", rdata, 16'h00D1);
        wr = 1; wd = 16'h00F0; cyc("R5 clear while above");
        check("R5 stays clear literal", rdata, 16'h0001);
        cyc("R5 no re-set");
        tx = 0; cyc("R5 drop");
        tx = 9'd256; cyc("R5 re-arm");
        wr = 1; wd = 16'h0000; cyc("R7 zero write");
        rx = 9'd96; wr = 1; wd = 16'h0020; cyc("R8 set vs clear");
        check("R8 literal bit5", rdata & 16'h0020, 16'h0020);
        rdn = 1; wr = 1; wd = 16'h0001; cyc("R8 reset-done vs clear");
        wr = 1; wd = 16'h01F1; cyc("R7 clear all");
        ovl = 1; cyc("R6 overload");
        rdn = 1; cyc("R6 reset done");
        mbm = 8'h01; svld = 1; sidx = 0; rxp = 8'h01; cyc("R9 masked store");
        check("R9 masked literal", rdata & 16'h0006, 16'h0000);
        svld = 1; sidx = 1; rxp = 8'h03; cyc("R9 unmasked store");
        wr = 1; wd = 16'h0006; cyc("R9 write ignored");
        rxp = 8'h01; cyc("R9 masked pend only clears");
        svld = 1; srmt = 1; sidx = 2; rmp = 8'h04; rxp = 8'h04; cyc("R10 remote store");
        rmp = 0; cyc("R10 remote clear");
        rxp = 0; cyc("R9 rx clear");
        wr = 1; wd = 16'hFFFF; cyc("R11 write all");
        check("R11 reserved", rdata & 16'hFE08, 16'h0000);
        ovl = 1; cyc("R6 overload again");
        sel = 1; wr = 1; wd = 16'hFEFF; cyc("R12 mask load");
        sel = 0; cyc("R12 irq on unmasked bit");
        check("R12 irq literal", {15'd0, irq}, 16'd1);

        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 3 == 0) tx = pick_cnt();
            if ($urandom % 3 == 0) rx = pick_cnt();
            ovl  = ($urandom % 12 == 0);
            rdn  = ($urandom % 20 == 0);
            svld = ($urandom % 6 == 0);
            srmt = $urandom % 2;
            sidx = 3'($urandom);
            if ($urandom % 4 == 0) rxp = 8'($urandom) & 8'($urandom);
            if ($urandom % 4 == 0) rmp = 8'($urandom) & 8'($urandom);
            if ($urandom % 10 == 0) mbm = 8'($urandom);
            sel  = ($urandom % 8 == 0);
            wr   = ($urandom % 4 == 0);
            wd   = 16'($urandom);
            cyc("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog act=hung exp=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule